// File: doc/BRIEF.md
# Power Signature Sequencer

This block gives a core a switching signature that can be recognised later in its power draw. A pseudo-random sequence generator steps on each enabled clock. A separate leakage register holds an alternating bit pattern. That register rotates only on the enabled cycles where the current sequence bit is 1. The supply current therefore rises in bursts that follow a sequence the owner can compute.

An analysis tool can reproduce the sequence from the seed and the polynomial alone. It can then correlate the sequence with a power trace. The measurement and the correlation are outside this block. The sequence output and the leakage register contents are brought out to ports so that a bench can watch them.

Top module: `wm_power_mark`

## Requirements
- R1: While `rst` is high at a rising clock edge, the generator state loads the seed (default 16'hACE1). `seq_bit` then shows bit SEQ_W-1 of the seed. `leak_q` loads an alternating pattern with a 1 in its top bit (16'hAAAA for 16 bits).
- R2: The generator is a Fibonacci shift register that shifts towards the MSB. `seq_bit` is the state's top bit. The new LSB is the XOR of the tap bits. For SEQ_W=16 the taps are bits 15, 14, 12 and 3, which is the polynomial x^16+x^15+x^13+x^4+1.
- R3: On an edge where `en` is 1 and `seq_bit` is 1, `leak_q` rotates left by one position. The old top bit moves to bit 0.
- R4: On an edge where `en` is 1 and `seq_bit` is 0, `leak_q` keeps its value, and the generator still advances.
- R5: On an edge where `en` is 0, both `seq_bit` and `leak_q` (and the generator state behind them) keep their values.
- R6: Every rotation inverts every bit of `leak_q`. The register only ever holds the reset pattern or its complement.
- R7: The generator state is never all zeros. With the default settings, the output sequence repeats after exactly 65535 enabled cycles.
- R8: LEAK_W can be set to 16, 32 or 64, and each setting follows R1, R3, R4 and R6 at its own width.
- R9: A reset at any point restarts the same output sequence from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable for the generator and the leakage register |
| seq_bit | output | 1 | Current sequence bit (top bit of the generator state) |
| leak_q | output | LEAK_W | Leakage register contents |

## Verification
A generator state that is wrong shows up at `seq_bit` within SEQ_W enabled cycles, because every state bit passes through the top position in that time. It also shows up in `leak_q`, because the register rotates on a different set of cycles from the one a reference model predicts. A wrong leakage value is visible on the very cycle it appears: it is no longer either the reset pattern or its complement. A rotation that goes missing or is added flips the expected polarity from that cycle onward. A broken enable shows up one cycle after the edge as a value that changed when it should have held.

// File: rtl/wm_pkg.sv
package wm_pkg;

    // Tap masks for maximal-length Fibonacci polynomials; bit k set means
    // state bit k feeds the XOR. Zero marks an unsupported width.
    function automatic logic [63:0] tap_mask(input int w);
        logic [63:0] m;
        case (w)
            8:       m = 64'h0000_0000_0000_00B8;
            16:      m = 64'h0000_0000_0000_D008;
            24:      m = 64'h0000_0000_00E1_0000;
            32:      m = 64'h0000_0000_8020_0003;
            default: m = 64'h0;
        endcase
        return m;
    endfunction

    // Alternating pattern with a 1 in bit w-1 (w even).
    function automatic logic [63:0] alt_pattern(input int w);
        logic [63:0] p;
        p = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) p[i] = ((i % 2) == ((w - 1) % 2));
        end
        return p;
    endfunction

    typedef enum logic [1:0] {
        WM_HOLD  = 2'd0,
        WM_IDLE  = 2'd1,
        WM_SHIFT = 2'd2
    } wm_act_e;

    typedef struct packed {
        logic advance;
        logic rotate;
    } wm_ctl_t;

endpackage

// File: rtl/wm_ctrl.sv
module wm_ctrl
    import wm_pkg::*;
(
    input  logic    en,
    input  logic    seq_bit,
    output wm_ctl_t ctl
);
    wm_act_e act;

    always_comb begin
        if (!en)          act = WM_HOLD;
        else if (seq_bit) act = WM_SHIFT;
        else              act = WM_IDLE;
    end

    always_comb begin
        ctl.advance = (act != WM_HOLD);
        ctl.rotate  = (act == WM_SHIFT);
    end
endmodule

// File: rtl/wm_seq_gen.sv
module wm_seq_gen
    import wm_pkg::*;
#(
    parameter int               SEQ_W = 16,
    parameter logic [SEQ_W-1:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [SEQ_W-1:0] state_q,
    output logic             out_bit
);
    localparam logic [63:0]      TAPS64 = tap_mask(SEQ_W);
    localparam logic [SEQ_W-1:0] TAPS   = TAPS64[SEQ_W-1:0];

    generate
        if (TAPS64 == 64'h0) begin : g_bad_width
            $error("wm_seq_gen: unsupported SEQ_W");
        end
        if (SEED == '0) begin : g_bad_seed
            $error("wm_seq_gen: seed must be nonzero");
        end
    endgenerate

    logic fb;
    assign fb      = ^(state_q & TAPS);
    assign out_bit = state_q[SEQ_W-1];

    always_ff @(posedge clk) begin
        if (rst)          state_q <= SEED;
        else if (advance) state_q <= {state_q[SEQ_W-2:0], fb};
    end
endmodule

// File: rtl/wm_leak_reg.sv
module wm_leak_reg
    import wm_pkg::*;
#(
    parameter int LEAK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rotate,
    output logic [LEAK_W-1:0] q
);
    localparam logic [63:0]       PAT64 = alt_pattern(LEAK_W);
    localparam logic [LEAK_W-1:0] PAT   = PAT64[LEAK_W-1:0];

    generate
        if (!(LEAK_W == 16 || LEAK_W == 32 || LEAK_W == 64)) begin : g_bad_width
            $error("wm_leak_reg: LEAK_W must be 16, 32 or 64");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)         q <= PAT;
        else if (rotate) q <= {q[LEAK_W-2:0], q[LEAK_W-1]};
    end
endmodule

// File: rtl/wm_power_mark.sv
module wm_power_mark
    import wm_pkg::*;
#(
    parameter int               SEQ_W  = 16,
    parameter int               LEAK_W = 16,
    parameter logic [SEQ_W-1:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic              seq_bit,
    output logic [LEAK_W-1:0] leak_q
);
    wm_ctl_t          ctl;
    logic [SEQ_W-1:0] seq_state;

    wm_seq_gen #(.SEQ_W(SEQ_W), .SEED(SEED)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (ctl.advance),
        .state_q (seq_state),
        .out_bit (seq_bit)
    );

    wm_ctrl u_ctrl (
        .en      (en),
        .seq_bit (seq_bit),
        .ctl     (ctl)
    );

    wm_leak_reg #(.LEAK_W(LEAK_W)) u_leak (
        .clk    (clk),
        .rst    (rst),
        .rotate (ctl.rotate),
        .q      (leak_q)
    );
endmodule

// File: rtl/wm_power_mark_chk.sv
module wm_power_mark_chk
    import wm_pkg::*;
#(
    parameter int SEQ_W  = 16,
    parameter int LEAK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              seq_bit,
    input logic [LEAK_W-1:0] leak_q,
    input logic [SEQ_W-1:0]  seq_state
);
    localparam logic [63:0]       PAT64 = alt_pattern(LEAK_W);
    localparam logic [LEAK_W-1:0] PAT   = PAT64[LEAK_W-1:0];

    logic [LEAK_W-1:0] leak_d;
    always_ff @(posedge clk) leak_d <= leak_q;

    p_rotate_r3: assert property (@(posedge clk) disable iff (rst)
        (en && seq_bit) |=> (leak_q == {leak_d[LEAK_W-2:0], leak_d[LEAK_W-1]}));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !seq_bit) |=> $stable(leak_q));

    p_off_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(leak_q) && $stable(seq_state) && $stable(seq_bit)));

    p_polarity_r6: assert property (@(posedge clk) disable iff (rst)
        (leak_q == PAT) || (leak_q == ~PAT));

    p_invert_r6: assert property (@(posedge clk) disable iff (rst)
        (en && seq_bit) |=> (leak_q == ~leak_d));

    p_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        seq_state != '0);
endmodule

bind wm_power_mark wm_power_mark_chk #(.SEQ_W(SEQ_W), .LEAK_W(LEAK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seq_bit   (seq_bit),
    .leak_q    (leak_q),
    .seq_state (seq_state)
);

// File: tb/wm_power_mark_bench.sv
module wm_power_mark_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        seq_bit, seq_bit64;
    logic [15:0] leak16;
    logic [63:0] leak64;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0] m_s;
    logic [15:0] m_l16;
    logic [63:0] m_l64;

    wm_power_mark u_wm_power_mark (
        .clk(clk), .rst(rst), .en(en), .seq_bit(seq_bit), .leak_q(leak16)
    );

    wm_power_mark #(.LEAK_W(64)) u_wm_power_mark_w64 (
        .clk(clk), .rst(rst), .en(en), .seq_bit(seq_bit64), .leak_q(leak64)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                chk(1'b0, "watchdog", 64'(cycles), 64'd190000);
                summary();
            end
        end
    end

    // Compare both instances with the reference model.
    task automatic compare(input string req);
        chk(seq_bit === m_s[15], req, {63'b0, seq_bit}, {63'b0, m_s[15]});
        chk(leak16 === m_l16, req, {48'b0, leak16}, {48'b0, m_l16});
        chk(leak64 === m_l64, {req, " R8"}, leak64, m_l64);
        chk(seq_bit64 === m_s[15], {req, " R8"}, {63'b0, seq_bit64}, {63'b0, m_s[15]});
    endtask

    // One clock with the given enable; called at a falling edge.
    task automatic step(input logic e, input string req);
        logic b;
        en = e;
        b  = m_s[15];
        if (e) begin
            if (b) begin
                m_l16 = {m_l16[14:0], m_l16[15]};
                m_l64 = {m_l64[62:0], m_l64[63]};
            end
            m_s = {m_s[14:0], m_s[15] ^ m_s[14] ^ m_s[12] ^ m_s[3]};
        end
        @(negedge clk);
        compare(req);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        en  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst   = 1'b0;
        m_s   = 16'hACE1;
        m_l16 = 16'hAAAA;
        m_l64 = 64'hAAAA_AAAA_AAAA_AAAA;
        compare("R1");
    endtask

    task automatic t_run();
        t_reset();
        for (int i = 0; i < 200; i++) step(1'b1, "R2 R3 R4");
    endtask

    task automatic t_gated();
        logic [15:0] held;
        t_reset();
        for (int i = 0; i < 20; i++) step(1'b1, "R2");
        held = leak16;
        for (int i = 0; i < 8; i++) step(1'b0, "R5");
        chk(leak16 === held, "R5 hold across gap", {48'b0, leak16}, {48'b0, held});
        for (int i = 0; i < 150; i++) step((i % 3) != 0, "R5 mixed");
    endtask

    task automatic t_invert();
        logic [15:0] prev;
        int          rot = 0;
        t_reset();
        for (int i = 0; i < 64; i++) begin
            prev = leak16;
            if (seq_bit) begin
                step(1'b1, "R6");
                chk(leak16 === ~prev, "R6 full toggle", {48'b0, leak16}, {48'b0, ~prev});
                rot++;
            end else begin
                step(1'b1, "R4");
            end
        end
        chk(rot > 0, "R6 rotations seen", 64'(rot), 64'd1);
    endtask

    task automatic t_period();
        logic [15:0] head, tail;
        t_reset();
        for (int i = 0; i < 16; i++) begin
            head[i] = seq_bit;
            step(1'b1, "R7");
        end
        for (int i = 16; i < 65535; i++) step(1'b1, "R7");
        for (int i = 0; i < 16; i++) begin
            tail[i] = seq_bit;
            step(1'b1, "R7");
        end
        chk(head === tail, "R7 period 65535", {48'b0, tail}, {48'b0, head});
    endtask

    task automatic t_restart();
        logic [36:0] first, second;
        t_reset();
        for (int i = 0; i < 37; i++) begin
            first[i] = seq_bit;
            step(1'b1, "R9");
        end
        t_reset();
        for (int i = 0; i < 37; i++) begin
            second[i] = seq_bit;
            step(1'b1, "R9");
        end
        chk(first === second, "R9 restart", {27'b0, second}, {27'b0, first});
    endtask

    initial begin
        @(negedge clk);
        t_run();
        t_gated();
        t_invert();
        t_restart();
        t_period();
        summary();
    end
endmodule